// File: doc/BRIEF.md
# Polyphase Horizontal Line Resampler

This block resizes one line of 8-bit samples from a programmed source width to a programmed destination width. A single write port fills a bank of 32 filter phases, each holding eight signed 8-bit taps whose sum is 64, and sets four scalar settings: a 16.16 step ratio, a 32-bit starting position, the source width and the destination width. A start pulse opens a line. The block then takes exactly the source width of samples over a valid/ready handshake into a line store. After that it emits the destination width of filtered samples on consecutive cycles and ends with a one-cycle done pulse.

For each output the running position holds a source index in its upper 16 bits and a phase in fraction bits [15:11]. The eight taps of that phase are applied to the source samples centred on the index. The weighted sum is rounded, divided by 64 and clamped to the 8-bit range. Samples that would fall outside the line are replaced by the nearest end sample. The step is normally set to (source_width << 16) / destination_width.

Top module: `hscale_poly`

## Requirements
- R1: While reset is held, and on the first cycle after reset, in_ready_o, out_valid_o and done_o are low.
- R2: A write with cfg_addr_i bit 6 clear stores cfg_wdata_i as coefficient word cfg_addr_i[5:0], where bits [5:1] are the phase and bit 0 selects the word; byte b (bits 8b+7..8b) of word w is signed tap 4w+b. Addresses 64, 65, 66 and 67 hold the step, the starting position, the source width and the destination width.
- R3: in_ready_o rises after start_i and stays high until exactly source-width samples have been accepted, and it is low whenever out_valid_o is high.
- R4: Output n uses position P = start + n*step (modulo 2^32), with index P[31:16] and phase P[15:11].
- R5: Tap k (0..7) weighs source sample index+k-3, and that sample index is clamped into 0..source_width-1.
- R6: The output is (sum + 32) shifted right arithmetically by 6, then clamped to 0..255.
- R7: Exactly destination-width outputs are produced for each line, on consecutive cycles and in order.
- R8: done_o is a single-cycle pulse in the cycle right after the last output of a line, with out_valid_o low.
- R9: start_i has no effect while a line is being loaded or emitted.
- R10: A phase whose only non-zero tap is tap 3 = 64 reproduces the source samples unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Settings write strobe |
| cfg_addr_i | input | 7 | Settings word address |
| cfg_wdata_i | input | 32 | Settings write data |
| start_i | input | 1 | Begins a line when idle |
| in_valid_i | input | 1 | Source sample is valid |
| in_data_i | input | 8 | Source sample |
| in_ready_o | output | 1 | Block accepts a source sample |
| out_valid_o | output | 1 | Output sample is valid |
| out_data_o | output | 8 | Output sample |
| done_o | output | 1 | Line complete pulse |

## Verification
A unit step with zero start and a ramp input checks the pass-through phase and the exact index walk. A 2:1 reduction with a filter that has negative outer taps separates correct tap alignment and left-edge replication from off-by-one windows. Upscaling a 0/255 alternating line from a non-zero start drives the sum past both rails, so it checks the rounding and clamping and the right-edge replication. A one-sample line and a full 64-sample line with a half-phase start, input gaps and stray start pulses cover the width limits, the flow control and the rule that start is ignored mid-line.

// File: rtl/hscale_pkg.sv
package hscale_pkg;
  localparam int PIX_W         = 8;
  localparam int CW            = 8;
  localparam int TAPS          = 8;
  localparam int NPH           = 32;
  localparam int TAPS_PER_WORD = 4;
  localparam int WORDS_PER_PH  = TAPS / TAPS_PER_WORD;
  localparam int CENTER        = 3;
  localparam int NORM_SH       = 6;
  localparam int ADDR_W        = 7;
  localparam int PH_W          = $clog2(NPH);

  localparam logic [ADDR_W-1:0] A_STEP = 7'd64;
  localparam logic [ADDR_W-1:0] A_INIT = 7'd65;
  localparam logic [ADDR_W-1:0] A_INW  = 7'd66;
  localparam logic [ADDR_W-1:0] A_OUTW = 7'd67;

  typedef logic signed [CW-1:0] tap_t;
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} state_e;
endpackage

// File: rtl/hscale_cfg.sv
module hscale_cfg
  import hscale_pkg::*;
#(
  parameter int IW = 7,
  parameter int OW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [PH_W-1:0]     phase_i,
  output tap_t [TAPS-1:0]     taps_o,
  output logic [31:0]         step_o,
  output logic [31:0]         init_o,
  output logic [IW-1:0]       in_w_o,
  output logic [OW-1:0]       out_w_o
);
  localparam int NWORDS = NPH * WORDS_PER_PH;
  localparam int CA_W   = $clog2(NWORDS);

  logic [31:0] coef_q [NWORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NWORDS; i++) coef_q[i] <= '0;
      step_o  <= '0;
      init_o  <= '0;
      in_w_o  <= '0;
      out_w_o <= '0;
    end else if (we_i) begin
      if (!addr_i[ADDR_W-1]) begin
        coef_q[addr_i[CA_W-1:0]] <= wdata_i;
      end else begin
        case (addr_i)
          A_STEP:  step_o  <= wdata_i;
          A_INIT:  init_o  <= wdata_i;
          A_INW:   in_w_o  <= wdata_i[IW-1:0];
          A_OUTW:  out_w_o <= wdata_i[OW-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam int W = k / TAPS_PER_WORD;
    localparam int B = k % TAPS_PER_WORD;
    logic [CA_W-1:0] wsel;
    assign wsel      = CA_W'(int'(phase_i) * WORDS_PER_PH + W);
    assign taps_o[k] = coef_q[wsel][B*CW +: CW];
  end
endmodule

// File: rtl/hscale_linebuf.sv
module hscale_linebuf
  import hscale_pkg::*;
#(
  parameter int MAX_W = 64,
  parameter int IW    = $clog2(MAX_W + 1),
  parameter int AW    = $clog2(MAX_W)
) (
  input  logic                        clk_i,
  input  logic                        we_i,
  input  logic [AW-1:0]               waddr_i,
  input  logic [PIX_W-1:0]            wdata_i,
  input  logic [15:0]                 pos_i,
  input  logic [IW-1:0]               in_w_i,
  output logic [TAPS-1:0][PIX_W-1:0]  win_o
);
  localparam int XW = 18;

  logic [PIX_W-1:0] mem [MAX_W];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  logic signed [XW-1:0] last;
  assign last = $signed(XW'(in_w_i)) - XW'(1);

  for (genvar k = 0; k < TAPS; k++) begin : g_win
    localparam logic signed [XW-1:0] OFF = XW'(k - CENTER);
    logic signed [XW-1:0] raw;
    logic [AW-1:0]        sel;
    assign raw = $signed({2'b00, pos_i}) + OFF;
    always_comb begin
      if (raw < 0)         sel = '0;
      else if (raw > last) sel = last[AW-1:0];
      else                 sel = raw[AW-1:0];
    end
    assign win_o[k] = mem[sel];
  end
endmodule

// File: rtl/hscale_mac.sv
module hscale_mac
  import hscale_pkg::*;
(
  input  tap_t [TAPS-1:0]             taps_i,
  input  logic [TAPS-1:0][PIX_W-1:0]  pix_i,
  output logic [PIX_W-1:0]            pix_o
);
  localparam int PW    = CW + PIX_W + 1;
  localparam int SUM_W = PW + $clog2(TAPS);
  localparam int PMAX  = (1 << PIX_W) - 1;

  logic signed [PW-1:0]    prod [TAPS];
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] rnd;

  for (genvar k = 0; k < TAPS; k++) begin : g_mul
    assign prod[k] = $signed(taps_i[k]) * $signed({1'b0, pix_i[k]});
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < TAPS; k++) sum = sum + SUM_W'(prod[k]);
  end

  assign rnd = (sum + SUM_W'(1 << (NORM_SH - 1))) >>> NORM_SH;

  always_comb begin
    if (rnd < 0)                   pix_o = '0;
    else if (rnd > SUM_W'(PMAX))   pix_o = PIX_W'(PMAX);
    else                           pix_o = rnd[PIX_W-1:0];
  end
endmodule

// File: rtl/hscale_poly.sv
module hscale_poly
  import hscale_pkg::*;
#(
  parameter int MAX_W = 64,
  parameter int OW    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [6:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic              done_o
);
  localparam int IW     = $clog2(MAX_W + 1);
  localparam int AW     = $clog2(MAX_W);
  localparam int PH_LSB = 16 - PH_W;

  state_e          state_q;
  logic [IW-1:0]   cnt_q;
  logic [31:0]     acc_q;
  logic [OW-1:0]   ocnt_q;
  logic            last_q;

  tap_t [TAPS-1:0]            taps;
  logic [TAPS-1:0][PIX_W-1:0] win;
  logic [PIX_W-1:0]           res;
  logic [31:0]                step, init;
  logic [IW-1:0]              in_w;
  logic [OW-1:0]              out_w;
  logic                       accept;

  assign in_ready_o = (state_q == S_LOAD);
  assign accept     = in_ready_o && in_valid_i;

  hscale_cfg #(.IW(IW), .OW(OW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .phase_i (acc_q[PH_LSB +: PH_W]),
    .taps_o  (taps),
    .step_o  (step),
    .init_o  (init),
    .in_w_o  (in_w),
    .out_w_o (out_w)
  );

  hscale_linebuf #(.MAX_W(MAX_W), .IW(IW), .AW(AW)) u_line (
    .clk_i   (clk_i),
    .we_i    (accept),
    .waddr_i (cnt_q[AW-1:0]),
    .wdata_i (in_data_i),
    .pos_i   (acc_q[31:16]),
    .in_w_i  (in_w),
    .win_o   (win)
  );

  hscale_mac u_mac (
    .taps_i (taps),
    .pix_i  (win),
    .pix_o  (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      acc_q       <= '0;
      ocnt_q      <= '0;
      last_q      <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      done_o      <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      last_q      <= 1'b0;
      done_o      <= out_valid_o && last_q;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            state_q <= S_LOAD;
            cnt_q   <= '0;
            ocnt_q  <= '0;
            acc_q   <= init;
          end
        end
        S_LOAD: begin
          if (in_valid_i) begin
            cnt_q <= cnt_q + IW'(1);
            if (cnt_q == in_w - IW'(1)) state_q <= S_RUN;
          end
        end
        S_RUN: begin
          out_valid_o <= 1'b1;
          out_data_o  <= res;
          acc_q       <= acc_q + step;
          ocnt_q      <= ocnt_q + OW'(1);
          if (ocnt_q == out_w - OW'(1)) begin
            last_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hscale_poly_chk.sv
module hscale_poly_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic out_valid_o,
  input logic done_o
);
  // R3: loading and emitting never overlap
  assert_ready_excl_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  // R3: ready only drops through an accepted sample
  assert_ready_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> in_ready_o);

  // R7: output burst ends only where the line ends
  assert_burst_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> done_o);

  // R8: done follows an output and carries none itself
  assert_done_after_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(out_valid_o) && !out_valid_o));

  // R8: single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind hscale_poly hscale_poly_chk u_chk (.*);

// File: tb/tb_hscale_poly.sv
module tb_hscale_poly;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        start_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_ready_o, out_valid_o, done_o;
  logic [7:0]  out_data_o;

  int n_tests = 0;
  int n_fail  = 0;
  int coef_m [32][8];
  int pix_m  [64];
  int exp_q  [$];
  int mon_e;
  int done_cnt = 0;
  bit prev_valid = 1'b0;
  string cur_tag = "R4";

  always #10 clk = ~clk;

  hscale_poly dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_addr_i  (cfg_addr),
    .cfg_wdata_i (cfg_wdata),
    .start_i     (start_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .done_o      (done_o)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 extra output", int'(out_data_o), -1);
        else begin
          mon_e = exp_q.pop_front();
          chk(int'(out_data_o) == mon_e, cur_tag, int'(out_data_o), mon_e);
        end
      end
      if (done_o) begin
        done_cnt++;
        chk(prev_valid && exp_q.size() == 0, "R8 done timing", exp_q.size(), 0);
      end
      prev_valid = out_valid_o;
    end
  end

  task automatic cfg_wr(int addr, int data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 7'(addr);
    cfg_wdata = 32'(data);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // kind 0: linear two-tap; kind 1: six-tap with negative lobes (R2 packing)
  task automatic load_table(int kind);
    for (int p = 0; p < 32; p++) begin
      for (int k = 0; k < 8; k++) coef_m[p][k] = 0;
      if (p == 0 || kind == 0) begin
        coef_m[p][3] = 64 - 2 * p;
        coef_m[p][4] = 2 * p;
      end else begin
        coef_m[p][0] = 1;
        coef_m[p][2] = -6;
        coef_m[p][3] = 70 - 2 * p;
        coef_m[p][4] = 6 + 2 * p;
        coef_m[p][5] = -6;
        coef_m[p][7] = -1;
      end
    end
    for (int p = 0; p < 32; p++) begin
      for (int w = 0; w < 2; w++) begin
        int word = 0;
        for (int b = 0; b < 4; b++) word = word | ((coef_m[p][4*w+b] & 255) << (8 * b));
        cfg_wr(p * 2 + w, word);
      end
    end
  endtask

  task automatic build_exp(int in_w, int out_w, int step, int init);
    for (int n = 0; n < out_w; n++) begin
      longint a = (longint'(unsigned'(init)) + longint'(n) * longint'(unsigned'(step))) & 64'hFFFF_FFFF;
      int pos = int'(a >> 16);
      int ph  = int'((a >> 11) & 31);
      int s   = 0;
      int r;
      for (int k = 0; k < 8; k++) begin
        int idx = pos + k - 3;
        if (idx < 0) idx = 0;
        if (idx > in_w - 1) idx = in_w - 1;
        s = s + coef_m[ph][k] * pix_m[idx];
      end
      r = (s + 32) >>> 6;
      if (r < 0) r = 0;
      if (r > 255) r = 255;
      exp_q.push_back(r);
    end
  endtask

  task automatic run_line(string tag, int in_w, int out_w, int step, int init, bit gap, bit poke);
    int i = 0;
    int cyc = 0;
    cfg_wr(64, step);
    cfg_wr(65, init);
    cfg_wr(66, in_w);
    cfg_wr(67, out_w);
    build_exp(in_w, out_w, step, init);
    cur_tag  = tag;
    done_cnt = 0;
    @(negedge clk);
    chk(in_ready_o == 1'b0, "R3 idle not ready", int'(in_ready_o), 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (i < in_w) begin
      if (gap && (cyc % 3 == 2)) in_valid_i = 1'b0;
      else if (in_ready_o) begin
        in_valid_i = 1'b1;
        in_data_i  = 8'(pix_m[i]);
        i++;
      end else in_valid_i = 1'b0;
      if (poke) start_i = (cyc == 3);
      cyc++;
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    start_i    = 1'b0;
    chk(in_ready_o == 1'b0, "R3 ready after last sample", int'(in_ready_o), 0);
    if (poke) begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int t = 0; t < 5000 && done_cnt == 0; t++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(done_cnt == 1, "R8 done count", done_cnt, 1);
    chk(exp_q.size() == 0, "R7 missing outputs", exp_q.size(), 0);
    chk(in_ready_o == 1'b0 && out_valid_o == 1'b0, "R9 idle after line", int'(in_ready_o), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(in_ready_o == 0 && out_valid_o == 0 && done_o == 0, "R1 in reset", int'(out_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready_o == 0 && out_valid_o == 0 && done_o == 0, "R1 after reset", int'(done_o), 0);

    // R10 R4: unit step, phase 0 only
    load_table(0);
    for (int i = 0; i < 64; i++) pix_m[i] = (i * 13 + 5) % 256;
    run_line("R10 R4 identity", 16, 16, 1 << 16, 0, 1'b0, 1'b0);

    // R5 R2: 2:1 reduction, negative lobes, left edge
    load_table(1);
    for (int i = 0; i < 64; i++) pix_m[i] = (i * 37 + 11) % 256;
    run_line("R5 R2 reduce", 40, 20, (40 << 16) / 20, 0, 1'b0, 1'b0);

    // R6 R5: upscale of 0/255 edges from non-zero start
    for (int i = 0; i < 64; i++) pix_m[i] = (i % 2) ? 255 : 0;
    run_line("R6 R5 upscale clamp", 10, 23, (10 << 16) / 23, 32'h400, 1'b0, 1'b0);

    // R5: single sample line, all taps replicate
    pix_m[0] = 200;
    run_line("R5 single sample", 1, 5, (1 << 16) / 5, 32'hC000, 1'b0, 1'b0);

    // R9 R3 R4: full width, half phase start, gaps, stray starts
    load_table(0);
    for (int i = 0; i < 64; i++) pix_m[i] = (i * 53 + 7) % 256;
    run_line("R9 R3 R4 full width", 64, 64, 1 << 16, 32'h8000, 1'b1, 1'b1);

    // R6 R2: second pass with a 3:2 ratio on the lobed table
    load_table(1);
    for (int i = 0; i < 64; i++) pix_m[i] = (i < 20) ? 250 : 3;
    run_line("R6 R2 ratio 3:2", 48, 32, (48 << 16) / 32, 0, 1'b1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule